// File: doc/BRIEF.md
# Two-Channel Parallel Port Strobe/Ready Handshake

This block runs the data handshake for both channels of a two-channel parallel port. For each channel it drives a READY line to the peripheral and accepts a STROBE line from it. It keeps two flags per channel: one shows that CPU output data is waiting for the peripheral, and the other shows that the input latch has been read and is free for new data. It also keeps an interrupt request flag per channel. The block learns the current mode of each channel from the control logic, which pulses a mode-write input whenever a mode is rewritten. It is also told of every CPU data read and data write on each channel.

A rising STROBE edge completes a transfer. In output mode the edge acknowledges the waiting data. In input mode it latches the peripheral pins into the channel's data register. In both cases it raises the channel's interrupt request, which the interrupt logic clears with an acknowledge pulse. When channel A is bidirectional, A's own strobe serves its output direction. Channel B's strobe and READY are then lent to A's input direction, and channel B carries out no handshake of its own. In bit-control mode there is no handshake: the data register follows the pins, and a pulse flags each change so that the bit-control condition can be evaluated again.

Mode encoding on `mode_a`/`mode_b`: 2'b00 output, 2'b01 input, 2'b10 bidirectional, 2'b11 bit-control.

Top module: `pio_hsk_ctrl`

## Requirements
- R1: After reset, READY, the interrupt requests, the data registers and the change pulses of both channels are 0.
- R2: In output (00) or bidirectional (10) mode, a CPU data write sets the channel's output-ready flag. READY goes to 1 on the second rising clock edge after the write is sampled.
- R3: In output mode, a rising STROBE edge clears output-ready and sets the interrupt request. The interrupt request shows after that edge, and READY falls one edge later.
- R4: In input mode (01), a rising STROBE edge loads the pins into the data register, clears input-empty and sets the interrupt request. A CPU data read sets input-empty. READY follows input-empty with one cycle of delay.
- R5: While channel A is bidirectional, READY of channel B shows A's input-empty flag one cycle later. A rising edge on channel B's STROBE loads channel A's pins into A's data register and sets A's interrupt request. Channel A's own STROBE serves A's output direction.
- R6: While channel A is bidirectional, CPU reads, CPU writes and STROBE edges on channel B do not change B's interrupt request or B's flags.
- R7: In bit-control mode (11), READY is 0 and STROBE is ignored. The data register takes the pins each cycle, and the change pulse is 1 for one cycle after the pins differ from the register.
- R8: A mode-write pulse clears the channel's output-ready, input-empty and interrupt request flags. It takes priority over every other event in that cycle.
- R9: An acknowledge pulse clears the interrupt request. If a transfer-completing STROBE edge comes in the same cycle, the request stays set.
- R10: If a CPU write and a STROBE edge come in the same cycle, output-ready ends set. If a CPU read and an input STROBE edge come in the same cycle, input-empty ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_a | input | 2 | Current mode of channel A |
| mode_b | input | 2 | Current mode of channel B |
| mode_wr_a | input | 1 | Pulse: channel A mode was rewritten |
| mode_wr_b | input | 1 | Pulse: channel B mode was rewritten |
| cpu_wr_a | input | 1 | Pulse: CPU wrote channel A data |
| cpu_wr_b | input | 1 | Pulse: CPU wrote channel B data |
| cpu_rd_a | input | 1 | Pulse: CPU read channel A data |
| cpu_rd_b | input | 1 | Pulse: CPU read channel B data |
| irq_ack_a | input | 1 | Pulse: clear channel A interrupt request |
| irq_ack_b | input | 1 | Pulse: clear channel B interrupt request |
| strobe_a | input | 1 | Peripheral strobe, channel A (rising edge active) |
| strobe_b | input | 1 | Peripheral strobe, channel B (rising edge active) |
| pin_a | input | DW | Peripheral data pins, channel A |
| pin_b | input | DW | Peripheral data pins, channel B |
| ready_a | output | 1 | Registered READY, channel A |
| ready_b | output | 1 | Registered READY, channel B |
| irq_a | output | 1 | Interrupt request flag, channel A |
| irq_b | output | 1 | Interrupt request flag, channel B |
| data_a | output | DW | Input data register, channel A |
| data_b | output | DW | Input data register, channel B |
| bc_eval_a | output | 1 | Bit-control change pulse, channel A |
| bc_eval_b | output | 1 | Bit-control change pulse, channel B |

## Verification
Some properties are checked on every cycle: that an output-mode strobe sets the request and clears output-ready, that B's READY copies A's input-empty in the borrowed arrangement, that B's request stays frozen there, that READY stays low in bit-control, and that a mode write or an acknowledge clears the request. The bench covers what only a sequence of cycles can show. This includes the two-edge READY delay after a write or read, loading from the pins on a strobe, loading A's register from B's strobe, the change pulse in bit-control mode, and the set-wins collisions of R9 and R10. A long random run with occasional mode rewrites is compared cycle by cycle against a reference model in the bench.

// File: rtl/pio_hsk_pkg.sv
package pio_hsk_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    PM_OUT    = 2'b00,
    PM_IN     = 2'b01,
    PM_BIDIR  = 2'b10,
    PM_BITCTL = 2'b11
  } pmode_e;

  function automatic logic drives_out(input logic [1:0] m);
    return (m == PM_OUT) || (m == PM_BIDIR);
  endfunction

  function automatic logic takes_in(input logic [1:0] m);
    return (m == PM_IN) || (m == PM_BIDIR);
  endfunction

endpackage

// File: rtl/pio_hsk_edge.sv
module pio_hsk_edge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] strobe,
  output logic [NCH-1:0] rise
);

  logic [NCH-1:0] stb_q;
  logic [NCH-1:0] stb_d;

  always_comb begin
    stb_d = strobe;
    rise  = strobe & ~stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

endmodule

// File: rtl/pio_hsk_chan.sv
module pio_hsk_chan
  import pio_hsk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          mode_wr,
  input  logic          frozen,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          irq_ack,
  input  logic          rise_own,
  input  logic          rise_alt,
  input  logic [DW-1:0] pin,
  output logic          out_rdy,
  output logic          in_empty,
  output logic          irq,
  output logic [DW-1:0] data,
  output logic          bc_eval
);

  logic          out_rdy_q, out_rdy_d;
  logic          in_empty_q, in_empty_d;
  logic          irq_q, irq_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic          eval_q, eval_d;

  logic out_set, out_clr, in_load, rd_set, track;

  always_comb begin
    out_set = cpu_wr   && drives_out(mode) && !frozen;
    out_clr = rise_own && drives_out(mode) && !frozen;
    rd_set  = cpu_rd   && takes_in(mode)   && !frozen;
    in_load = !frozen &&
              (((mode == PM_IN) && rise_own) || ((mode == PM_BIDIR) && rise_alt));
    track   = (mode == PM_BITCTL);

    // R8: mode rewrite clears all flags first
    if (mode_wr) begin
      out_rdy_d  = 1'b0;
      in_empty_d = 1'b0;
      irq_d      = 1'b0;
    end else begin
      // R10: a set from the CPU side wins over the strobe clear
      if (out_set)      out_rdy_d = 1'b1;
      else if (out_clr) out_rdy_d = 1'b0;
      else              out_rdy_d = out_rdy_q;
      // R10: new data arriving wins over a read
      if (in_load)      in_empty_d = 1'b0;
      else if (rd_set)  in_empty_d = 1'b1;
      else              in_empty_d = in_empty_q;
      // R9: set wins over acknowledge
      if (out_clr || in_load) irq_d = 1'b1;
      else if (irq_ack)       irq_d = 1'b0;
      else                    irq_d = irq_q;
    end

    data_en = in_load || track;
    data_d  = pin;
    eval_d  = track && (pin != data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rdy_q  <= 1'b0;
      in_empty_q <= 1'b0;
      irq_q      <= 1'b0;
      eval_q     <= 1'b0;
    end else begin
      out_rdy_q  <= out_rdy_d;
      in_empty_q <= in_empty_d;
      irq_q      <= irq_d;
      eval_q     <= eval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign out_rdy  = out_rdy_q;
  assign in_empty = in_empty_q;
  assign irq      = irq_q;
  assign data     = data_q;
  assign bc_eval  = eval_q;

endmodule

// File: rtl/pio_hsk_ready.sv
module pio_hsk_ready
  import pio_hsk_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0][1:0] mode_v,
  input  logic [NCH-1:0]      out_rdy,
  input  logic [NCH-1:0]      in_empty,
  output logic [NCH-1:0]      ready
);

  logic [NCH-1:0] lvl_own;
  logic [NCH-1:0] lvl_next;
  logic [NCH-1:0] rdy_q;
  logic [NCH-1:0] rdy_en;
  logic           a_bidir;

  assign a_bidir = (mode_v[0] == PM_BIDIR);

  for (genvar g = 0; g < NCH; g++) begin : g_lvl
    always_comb begin
      if (drives_out(mode_v[g]))     lvl_own[g] = out_rdy[g];
      else if (mode_v[g] == PM_IN)   lvl_own[g] = in_empty[g];
      else                           lvl_own[g] = 1'b0;
    end
    if (g == 1) begin : g_borrow
      // R5: B's READY is lent to A's input direction
      assign lvl_next[g] = a_bidir ? in_empty[0] : lvl_own[g];
    end else begin : g_plain
      assign lvl_next[g] = lvl_own[g];
    end
  end

  assign rdy_en = lvl_next ^ rdy_q;

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdy_q[g] <= 1'b0;
      else if (rdy_en[g]) rdy_q[g] <= lvl_next[g];
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/pio_hsk_ctrl.sv
module pio_hsk_ctrl
  import pio_hsk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_a,
  input  logic [1:0]    mode_b,
  input  logic          mode_wr_a,
  input  logic          mode_wr_b,
  input  logic          cpu_wr_a,
  input  logic          cpu_wr_b,
  input  logic          cpu_rd_a,
  input  logic          cpu_rd_b,
  input  logic          irq_ack_a,
  input  logic          irq_ack_b,
  input  logic          strobe_a,
  input  logic          strobe_b,
  input  logic [DW-1:0] pin_a,
  input  logic [DW-1:0] pin_b,
  output logic          ready_a,
  output logic          ready_b,
  output logic          irq_a,
  output logic          irq_b,
  output logic [DW-1:0] data_a,
  output logic [DW-1:0] data_b,
  output logic          bc_eval_a,
  output logic          bc_eval_b
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ns = rst_sync_q[SYNC_N-1];

  logic [NCH-1:0][1:0]    mode_v;
  logic [NCH-1:0]         mode_wr_v, cpu_wr_v, cpu_rd_v, ack_v, strobe_v;
  logic [NCH-1:0][DW-1:0] pin_v, data_v;
  logic [NCH-1:0]         rise, out_rdy, in_empty, irq_v, eval_v, ready_v;
  logic                   a_bidir;

  assign mode_v    = {mode_b, mode_a};
  assign mode_wr_v = {mode_wr_b, mode_wr_a};
  assign cpu_wr_v  = {cpu_wr_b, cpu_wr_a};
  assign cpu_rd_v  = {cpu_rd_b, cpu_rd_a};
  assign ack_v     = {irq_ack_b, irq_ack_a};
  assign strobe_v  = {strobe_b, strobe_a};
  assign pin_v     = {pin_b, pin_a};
  assign a_bidir   = (mode_a == PM_BIDIR);

  pio_hsk_edge #(.NCH(NCH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_ns),
    .strobe (strobe_v),
    .rise   (rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic frz, alt;
    if (g == 0) begin : g_a
      assign frz = 1'b0;
      assign alt = rise[1];
    end else begin : g_b
      assign frz = a_bidir;   // R6
      assign alt = 1'b0;
    end
    pio_hsk_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_ns),
      .mode     (mode_v[g]),
      .mode_wr  (mode_wr_v[g]),
      .frozen   (frz),
      .cpu_wr   (cpu_wr_v[g]),
      .cpu_rd   (cpu_rd_v[g]),
      .irq_ack  (ack_v[g]),
      .rise_own (rise[g]),
      .rise_alt (alt),
      .pin      (pin_v[g]),
      .out_rdy  (out_rdy[g]),
      .in_empty (in_empty[g]),
      .irq      (irq_v[g]),
      .data     (data_v[g]),
      .bc_eval  (eval_v[g])
    );
  end

  pio_hsk_ready #(.NCH(NCH)) u_ready (
    .clk      (clk),
    .rst_n    (rst_ns),
    .mode_v   (mode_v),
    .out_rdy  (out_rdy),
    .in_empty (in_empty),
    .ready    (ready_v)
  );

  assign ready_a   = ready_v[0];
  assign ready_b   = ready_v[1];
  assign irq_a     = irq_v[0];
  assign irq_b     = irq_v[1];
  assign data_a    = data_v[0];
  assign data_b    = data_v[1];
  assign bc_eval_a = eval_v[0];
  assign bc_eval_b = eval_v[1];

endmodule

// File: rtl/pio_hsk_chk.sv
module pio_hsk_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic [1:0] mode_a,
  input logic       mode_wr_a,
  input logic       mode_wr_b,
  input logic       cpu_wr_a,
  input logic       irq_ack_a,
  input logic       irq_ack_b,
  input logic       ready_a,
  input logic       ready_b,
  input logic       irq_a,
  input logic       irq_b,
  input logic [1:0] out_rdy,
  input logic [1:0] in_empty,
  input logic [1:0] rise
);

  a_r3_strobe_sets_irq: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_a == 2'b00 && rise[0] && !mode_wr_a && !cpu_wr_a) |=> (irq_a && !out_rdy[0]));

  a_r5_b_ready_borrowed: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_a == 2'b10) |=> (ready_b == $past(in_empty[0])));

  a_r6_b_irq_frozen: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_a == 2'b10 && !mode_wr_b && !irq_ack_b) |=> (irq_b == $past(irq_b)));

  a_r7_bitctl_no_ready: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_a == 2'b11) |=> !ready_a);

  a_r8_mode_write_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    mode_wr_a |=> (!irq_a && !out_rdy[0] && !in_empty[0]));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_ack_a && mode_a == 2'b11 && !mode_wr_a) |=> !irq_a);

endmodule

bind pio_hsk_ctrl pio_hsk_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .mode_a    (mode_a),
  .mode_wr_a (mode_wr_a),
  .mode_wr_b (mode_wr_b),
  .cpu_wr_a  (cpu_wr_a),
  .irq_ack_a (irq_ack_a),
  .irq_ack_b (irq_ack_b),
  .ready_a   (ready_a),
  .ready_b   (ready_b),
  .irq_a     (irq_a),
  .irq_b     (irq_b),
  .out_rdy   (out_rdy),
  .in_empty  (in_empty),
  .rise      (rise)
);

// File: tb/tb_pio_hsk_ctrl.sv
module tb_pio_hsk_ctrl;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    mode   [2];
  logic          mwr    [2];
  logic          cwr    [2];
  logic          crd    [2];
  logic          ack    [2];
  logic          stb    [2];
  logic [DW-1:0] pin    [2];
  logic          ready  [2];
  logic          irq    [2];
  logic [DW-1:0] data   [2];
  logic          eval_o [2];

  pio_hsk_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .mode_a(mode[0]), .mode_b(mode[1]),
    .mode_wr_a(mwr[0]), .mode_wr_b(mwr[1]),
    .cpu_wr_a(cwr[0]), .cpu_wr_b(cwr[1]),
    .cpu_rd_a(crd[0]), .cpu_rd_b(crd[1]),
    .irq_ack_a(ack[0]), .irq_ack_b(ack[1]),
    .strobe_a(stb[0]), .strobe_b(stb[1]),
    .pin_a(pin[0]), .pin_b(pin[1]),
    .ready_a(ready[0]), .ready_b(ready[1]),
    .irq_a(irq[0]), .irq_b(irq[1]),
    .data_a(data[0]), .data_b(data[1]),
    .bc_eval_a(eval_o[0]), .bc_eval_b(eval_o[1])
  );

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic          m_ordy [2];
  logic          m_iemp [2];
  logic          m_irq  [2];
  logic          m_rdy  [2];
  logic          m_eval [2];
  logic          m_stbq [2];
  logic [DW-1:0] m_dq   [2];

  function automatic logic f_out(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b10);
  endfunction

  function automatic logic f_in(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic f_ready_lvl(input int c);
    if (c == 1 && mode[0] == 2'b10) return m_iemp[0];
    if (f_out(mode[c]))             return m_ordy[c];
    if (mode[c] == 2'b01)           return m_iemp[c];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_update();
    logic nr [2];
    logic rise [2];
    for (int c = 0; c < 2; c++) nr[c] = f_ready_lvl(c);
    for (int c = 0; c < 2; c++) rise[c] = stb[c] & ~m_stbq[c];
    for (int c = 0; c < 2; c++) begin
      logic frz, alt, oset, oclr, load, rset, trk;
      frz  = (c == 1) && (mode[0] == 2'b10);
      alt  = (c == 0) ? rise[1] : 1'b0;
      oset = cwr[c] && f_out(mode[c]) && !frz;
      oclr = rise[c] && f_out(mode[c]) && !frz;
      rset = crd[c] && f_in(mode[c]) && !frz;
      load = !frz && ((mode[c] == 2'b01 && rise[c]) || (mode[c] == 2'b10 && alt));
      trk  = (mode[c] == 2'b11);
      m_eval[c] = trk && (pin[c] != m_dq[c]);
      if (load || trk) m_dq[c] = pin[c];
      if (mwr[c]) begin
        m_ordy[c] = 0; m_iemp[c] = 0; m_irq[c] = 0;
      end else begin
        if (oset) m_ordy[c] = 1; else if (oclr) m_ordy[c] = 0;
        if (load) m_iemp[c] = 0; else if (rset) m_iemp[c] = 1;
        if (oclr || load) m_irq[c] = 1; else if (ack[c]) m_irq[c] = 0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      m_rdy[c]  = nr[c];
      m_stbq[c] = stb[c];
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < 2; c++) begin
      chk({tag, " ready"}, 32'(ready[c]),  32'(m_rdy[c]));
      chk({tag, " irq"},   32'(irq[c]),    32'(m_irq[c]));
      chk({tag, " data"},  32'(data[c]),   32'(m_dq[c]));
      chk({tag, " eval"},  32'(eval_o[c]), 32'(m_eval[c]));
    end
  endtask

  // apply current inputs for one clock, then compare at the falling edge
  task automatic step(input string tag);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_pulses();
    for (int c = 0; c < 2; c++) begin
      mwr[c] = 0; cwr[c] = 0; crd[c] = 0; ack[c] = 0;
    end
  endtask

  task automatic set_mode(input int c, input logic [1:0] m, input string tag);
    mode[c] = m; mwr[c] = 1;
    step(tag);
    clear_pulses();
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 2; c++) begin
      mode[c] = 2'b01; stb[c] = 0; pin[c] = '0;
      m_ordy[c] = 0; m_iemp[c] = 0; m_irq[c] = 0; m_rdy[c] = 0;
      m_eval[c] = 0; m_stbq[c] = 0; m_dq[c] = '0;
    end
    clear_pulses();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 2; c++) begin
      chk("R1 ready", 32'(ready[c]), 0);
      chk("R1 irq",   32'(irq[c]), 0);
      chk("R1 data",  32'(data[c]), 0);
      chk("R1 eval",  32'(eval_o[c]), 0);
    end

    // R2: write in output mode raises READY two edges later
    set_mode(0, 2'b00, "R8 mode a out");
    cwr[0] = 1; step("R2 write");
    clear_pulses();
    chk("R2 ready not yet", 32'(ready[0]), 0);
    step("R2 wait");
    chk("R2 ready", 32'(ready[0]), 1);

    // R3: strobe acknowledges, raises irq
    stb[0] = 1; step("R3 strobe");
    chk("R3 irq", 32'(irq[0]), 1);
    stb[0] = 0; step("R3 after");
    chk("R3 ready fell", 32'(ready[0]), 0);

    // R9: ack clears irq; ack with strobe keeps it
    ack[0] = 1; step("R9 ack");
    clear_pulses();
    chk("R9 irq cleared", 32'(irq[0]), 0);
    cwr[0] = 1; step("R9 rearm"); clear_pulses();
    stb[0] = 1; ack[0] = 1; step("R9 ack with strobe");
    clear_pulses(); stb[0] = 0;
    chk("R9 set wins", 32'(irq[0]), 1);

    // R10: write and strobe together leave output-ready set
    step("R10 idle");
    stb[0] = 1; cwr[0] = 1; step("R10 collide");
    clear_pulses(); stb[0] = 0;
    step("R10 wait");
    chk("R10 ready set", 32'(ready[0]), 1);

    // R4: input mode on B
    set_mode(1, 2'b01, "R8 mode b in");
    crd[1] = 1; step("R4 read"); clear_pulses();
    step("R4 wait");
    chk("R4 ready empty", 32'(ready[1]), 1);
    pin[1] = 8'h5A; stb[1] = 1; step("R4 strobe");
    chk("R4 data", 32'(data[1]), 32'h5A);
    chk("R4 irq", 32'(irq[1]), 1);
    stb[1] = 0; step("R4 after");
    chk("R4 ready full", 32'(ready[1]), 0);

    // R5/R6: A bidirectional borrows B's lines
    ack[1] = 1; step("R6 clear b"); clear_pulses();
    set_mode(0, 2'b10, "R8 mode a bidir");
    crd[0] = 1; step("R5 read a"); clear_pulses();
    step("R5 wait");
    chk("R5 b ready follows a", 32'(ready[1]), 1);
    pin[0] = 8'hC3; pin[1] = 8'h11; stb[1] = 1; cwr[1] = 1; crd[1] = 1;
    step("R5 strobe b");
    clear_pulses();
    chk("R5 data a", 32'(data[0]), 32'hC3);
    chk("R5 irq a", 32'(irq[0]), 1);
    chk("R6 irq b", 32'(irq[1]), 0);
    chk("R6 data b", 32'(data[1]), 32'h5A);
    stb[1] = 0; step("R5 after");
    chk("R5 b ready fell", 32'(ready[1]), 0);

    // R7: bit-control mode
    set_mode(0, 2'b11, "R8 mode a bitctl");
    chk("R8 irq cleared", 32'(irq[0]), 0);
    pin[0] = 8'h3C; step("R7 pins change");
    chk("R7 data tracks", 32'(data[0]), 32'h3C);
    chk("R7 eval", 32'(eval_o[0]), 1);
    stb[0] = 1; step("R7 strobe");
    chk("R7 eval drop", 32'(eval_o[0]), 0);
    chk("R7 strobe ignored", 32'(irq[0]), 0);
    stb[0] = 0; step("R7 idle");
    chk("R7 ready low", 32'(ready[0]), 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom_range(0, 19) == 0) begin
          mode[c] = 2'($urandom_range(0, 3)); mwr[c] = 1;
        end
        cwr[c] = ($urandom_range(0, 3) == 0);
        crd[c] = ($urandom_range(0, 3) == 0);
        ack[c] = ($urandom_range(0, 5) == 0);
        stb[c] = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 3) == 0) pin[c] = DW'($urandom);
      end
      step("R10 random");
      clear_pulses();
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule